// File: doc/BRIEF.md
# Near-Segment Row Cache Manager

This block treats the short, fast segment of every DRAM subarray as a hardware-managed inclusive cache for the long, slow segment that shares its bitlines. For each subarray (one set per bank and subarray pair) it keeps one tag per fast row. Each tag holds a valid bit, a modified bit, the index of the slow-segment row whose contents it mirrors, and a recency age. Each incoming row request is looked up in its subarray's set. A hit returns the physical number of the fast row. A miss returns the physical number of the slow row and, in the same cycle, issues one in-subarray copy command.

Physical rows of a subarray are numbered from the sense amplifier outward. Rows `0 .. NEAR_ROWS-1` form the fast segment and rows `NEAR_ROWS .. BITLINE_CELLS-1` form the slow segment, so slow-segment index `f` sits at physical row `NEAR_ROWS + f`. A fill copies data by activating the slow source row and then the fast destination row, so the data crosses the shared bitlines without using the channel. If the fast row being reused holds modified data, the command first copies that row back to its own slow row, and then does the fill. The request's slow-row index must be below `BITLINE_CELLS - NEAR_ROWS`.

Top module: `near_row_cache`

## Requirements
- R1: After reset, `rsp_valid` and `mig_valid` are 0 and `mig_kind` is 0, and every set is empty, so the first request to any bank, subarray and row is a miss.
- R2: On a miss, `rsp_hit` is 0 and `rsp_row` is `NEAR_ROWS + req_row`. In the same cycle `mig_src_row` equals `rsp_row`, `mig_dst_row` is below `NEAR_ROWS`, and `mig_bank`/`mig_sub` repeat the request's bank and subarray.
- R3: A request for a slow row that is already cached is a hit. `rsp_hit` is 1 and `rsp_row` is the fast row (0..`NEAR_ROWS-1`) that the earlier fill wrote. No two tags of a set hold the same row.
- R4: `mig_valid` is 1 in exactly the cycles where `rsp_valid` is 1 and `rsp_hit` is 0.
- R5: While a set has empty fast rows, a miss fills the lowest-numbered empty one.
- R6: When a set is full, a miss replaces the least recently used fast row. Both hits and fills count as uses.
- R7: `mig_kind` is 0 when no command is issued. It is 1 (fill only: activate source, then destination) when the replaced fast row is empty or unmodified.
- R8: A write request (`req_write`=1) marks its fast row as modified, on a hit and on a miss alike. Replacing a modified row gives `mig_kind` 2: first copy the row `mig_dst_row` back to `mig_wb_row` = `NEAR_ROWS` + its slow index, then fill.
- R9: Sets are independent. A request to one bank and subarray never changes the hit or miss result in another.
- R10: Requests may arrive in back-to-back cycles to the same set, and each one sees the update made by the one before it.
- R11: A request sampled at a clock edge produces its response and command on the second following edge. One request may be sampled every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request writes the row |
| req_bank | input | BANK_W | Bank of the request |
| req_sub | input | SUB_W | Subarray within the bank |
| req_row | input | FAR_W | Slow-segment row index |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Row served from the fast segment |
| rsp_row | output | ROW_W | Physical row to access |
| mig_valid | output | 1 | Copy command present |
| mig_kind | output | 2 | 0 none, 1 fill, 2 write back then fill |
| mig_bank | output | BANK_W | Bank of the command |
| mig_sub | output | SUB_W | Subarray of the command |
| mig_src_row | output | ROW_W | Slow physical row to copy from |
| mig_dst_row | output | ROW_W | Fast physical row to copy into |
| mig_wb_row | output | ROW_W | Slow physical row receiving the write-back |

## Verification
The bench fills a set row by row and then forces replacements after a mix of hits. A design that searches empty rows in the wrong order, or that does not refresh recency on hits, then names the wrong destination row. Writes on a hit and on a miss are each followed by enough misses to evict the written row. A design that loses the modified bit issues a plain fill where a write-back is owed, and one that reports the wrong write-back row corrupts the slow copy. Two back-to-back requests to one set check that the second sees the first's fill; a design that reads stale tags reports a second miss and a duplicate tag. Requests to neighbouring sets check that no set leaks into another.

// File: rtl/nrc_pkg.sv
`timescale 1ns/1ps
package nrc_pkg;
  typedef enum logic [1:0] {
    MIG_NONE = 2'd0,
    MIG_FILL = 2'd1,
    MIG_SWAP = 2'd2
  } mig_kind_e;
endpackage

// File: rtl/nrc_tag_store.sv
`timescale 1ns/1ps
// One word per set, synchronous read, with a bypass for a write to the set being read.
module nrc_tag_store #(
  parameter int NUM_SETS = 256,
  parameter int SET_W    = 52,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SET_W-1:0] wr_data,
  output logic [SET_W-1:0] rd_data,
  output logic             rd_fresh
);
  logic [SET_W-1:0]    mem [NUM_SETS];
  logic [SET_W-1:0]    ram_q;
  logic [SET_W-1:0]    byp_q;
  logic                byp_sel;
  logic                fresh_q;
  logic [NUM_SETS-1:0] used;
  logic                same_idx;

  assign same_idx = wr_en && (wr_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    ram_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used    <= '0;
      byp_sel <= 1'b0;
      byp_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (wr_en) used[wr_idx] <= 1'b1;
      byp_sel <= same_idx;
      byp_q   <= wr_data;
      fresh_q <= used[rd_idx] | same_idx;
    end
  end

  assign rd_data  = byp_sel ? byp_q : ram_q;
  assign rd_fresh = fresh_q;

  // R10: a set written in one cycle is read back with that content in the next
  assert_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    same_idx |=> (rd_fresh && rd_data == $past(wr_data)));
endmodule

// File: rtl/nrc_set_lookup.sv
`timescale 1ns/1ps
// Tag compare, way choice and next set content for one request.
module nrc_set_lookup #(
  parameter int NEAR_ROWS = 4,
  parameter int FAR_W     = 9,
  parameter int WAY_W     = 2,
  localparam int ENT_W    = 2 + FAR_W + WAY_W,
  localparam int SET_W    = NEAR_ROWS * ENT_W
) (
  input  logic                 fresh,
  input  logic [SET_W-1:0]     set_in,
  input  logic [FAR_W-1:0]     req_row,
  input  logic                 req_write,
  output logic                 hit_o,
  output logic [NEAR_ROWS-1:0] match_o,
  output logic [WAY_W-1:0]     way_o,
  output logic                 vict_mod_o,
  output logic [FAR_W-1:0]     vict_tag_o,
  output logic [SET_W-1:0]     set_o
);
  logic [NEAR_ROWS-1:0] v, d, empty, sel;
  logic [FAR_W-1:0]     tag  [NEAR_ROWS];
  logic [WAY_W-1:0]     age  [NEAR_ROWS];
  logic [WAY_W-1:0]     aged [NEAR_ROWS];
  logic [WAY_W-1:0]     hit_way, free_way, lru_way, sel_age;
  logic                 new_mod;

  for (genvar w = 0; w < NEAR_ROWS; w++) begin : g_unpack
    assign v[w]       = fresh & set_in[w*ENT_W + ENT_W - 1];
    assign d[w]       = fresh & set_in[w*ENT_W + ENT_W - 2];
    assign tag[w]     = set_in[w*ENT_W + WAY_W +: FAR_W];
    assign age[w]     = fresh ? set_in[w*ENT_W +: WAY_W] : WAY_W'(w);
    assign match_o[w] = v[w] && (tag[w] == req_row);
    assign empty[w]   = !v[w];
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    for (int w = NEAR_ROWS - 1; w >= 0; w--) begin
      if (match_o[w]) hit_way = WAY_W'(w);
      if (empty[w]) free_way = WAY_W'(w);
      if (age[w] == WAY_W'(NEAR_ROWS - 1)) lru_way = WAY_W'(w);
    end
  end

  assign hit_o      = |match_o;
  assign way_o      = hit_o ? hit_way : ((|empty) ? free_way : lru_way);
  assign sel_age    = age[way_o];
  assign vict_mod_o = !hit_o && v[way_o] && d[way_o];
  assign vict_tag_o = tag[way_o];
  assign new_mod    = hit_o ? (d[way_o] | req_write) : req_write;

  for (genvar w = 0; w < NEAR_ROWS; w++) begin : g_pack
    assign sel[w]  = (way_o == WAY_W'(w));
    assign aged[w] = (age[w] < sel_age) ? age[w] + WAY_W'(1) : age[w];
    assign set_o[w*ENT_W +: ENT_W] = sel[w] ? {1'b1, new_mod, req_row, {WAY_W{1'b0}}}
                                            : {v[w], d[w], tag[w], aged[w]};
  end
endmodule

// File: rtl/near_row_cache.sv
`timescale 1ns/1ps
module near_row_cache #(
  parameter int NUM_BANKS     = 8,
  parameter int SUBS_PER_BANK = 32,
  parameter int BITLINE_CELLS = 512,
  parameter int NEAR_ROWS     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int SUB_W    = $clog2(SUBS_PER_BANK),
  localparam int ROW_W    = $clog2(BITLINE_CELLS),
  localparam int FAR_ROWS = BITLINE_CELLS - NEAR_ROWS,
  localparam int FAR_W    = $clog2(FAR_ROWS),
  localparam int WAY_W    = (NEAR_ROWS > 1) ? $clog2(NEAR_ROWS) : 1,
  localparam int NUM_SETS = NUM_BANKS * SUBS_PER_BANK,
  localparam int IDX_W    = $clog2(NUM_SETS),
  localparam int ENT_W    = 2 + FAR_W + WAY_W,
  localparam int SET_W    = NEAR_ROWS * ENT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [FAR_W-1:0]  req_row,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ROW_W-1:0]  rsp_row,
  output logic              mig_valid,
  output logic [1:0]        mig_kind,
  output logic [BANK_W-1:0] mig_bank,
  output logic [SUB_W-1:0]  mig_sub,
  output logic [ROW_W-1:0]  mig_src_row,
  output logic [ROW_W-1:0]  mig_dst_row,
  output logic [ROW_W-1:0]  mig_wb_row
);
  import nrc_pkg::*;

  localparam logic [ROW_W-1:0] NEAR_BASE = ROW_W'(NEAR_ROWS);

  logic              s1_valid, s1_write;
  logic [BANK_W-1:0] s1_bank;
  logic [SUB_W-1:0]  s1_sub;
  logic [FAR_W-1:0]  s1_row;
  logic [IDX_W-1:0]  s1_idx, req_idx;

  logic [SET_W-1:0]     set_rd, set_nx;
  logic                 set_fresh;
  logic                 hit;
  logic [NEAR_ROWS-1:0] match;
  logic [WAY_W-1:0]     way;
  logic                 vict_mod;
  logic [FAR_W-1:0]     vict_tag;

  assign req_idx = IDX_W'(req_bank) * IDX_W'(SUBS_PER_BANK) + IDX_W'(req_sub);

  // stage 1: capture request while the set word is read
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    s1_write <= req_write;
    s1_bank  <= req_bank;
    s1_sub   <= req_sub;
    s1_row   <= req_row;
    s1_idx   <= req_idx;
  end

  nrc_tag_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) i_store (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .wr_en    (s1_valid),
    .wr_idx   (s1_idx),
    .wr_data  (set_nx),
    .rd_data  (set_rd),
    .rd_fresh (set_fresh)
  );

  nrc_set_lookup #(.NEAR_ROWS(NEAR_ROWS), .FAR_W(FAR_W), .WAY_W(WAY_W)) i_lookup (
    .fresh      (set_fresh),
    .set_in     (set_rd),
    .req_row    (s1_row),
    .req_write  (s1_write),
    .hit_o      (hit),
    .match_o    (match),
    .way_o      (way),
    .vict_mod_o (vict_mod),
    .vict_tag_o (vict_tag),
    .set_o      (set_nx)
  );

  // stage 2: registered response and copy command
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      mig_valid <= 1'b0;
      mig_kind  <= MIG_NONE;
    end else begin
      rsp_valid <= s1_valid;
      rsp_hit   <= s1_valid && hit;
      mig_valid <= s1_valid && !hit;
      if (!s1_valid || hit) mig_kind <= MIG_NONE;
      else if (vict_mod)    mig_kind <= MIG_SWAP;
      else                  mig_kind <= MIG_FILL;
    end
  end

  always_ff @(posedge clk) begin
    rsp_row     <= hit ? ROW_W'(way) : NEAR_BASE + ROW_W'(s1_row);
    mig_bank    <= s1_bank;
    mig_sub     <= s1_sub;
    mig_src_row <= NEAR_BASE + ROW_W'(s1_row);
    mig_dst_row <= ROW_W'(way);
    mig_wb_row  <= NEAR_BASE + ROW_W'(vict_tag);
  end

  // R1: nothing issued in the cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !mig_valid && mig_kind == 2'd0));
  // R2: miss reports the slow row and copies it into a fast row
  assert_miss_rows_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_row >= NEAR_BASE && mig_src_row == rsp_row
                                 && mig_dst_row < NEAR_BASE));
  // R3: hit row lies in the fast segment; tags of a set are unique
  assert_hit_row_near_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_row < NEAR_BASE));
  assert_unique_tag_R3: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $onehot0(match));
  // R4: one command per miss, none otherwise
  assert_cmd_per_miss_R4: assert property (@(posedge clk) disable iff (rst)
    mig_valid == (rsp_valid && !rsp_hit));
  // R7: kind is zero exactly when no command is issued
  assert_kind_code_R7: assert property (@(posedge clk) disable iff (rst)
    mig_valid == (mig_kind != 2'd0));
  // R8: write-back targets a slow row other than the fill source
  assert_wb_row_R8: assert property (@(posedge clk) disable iff (rst)
    (mig_valid && mig_kind == 2'd2) |-> (mig_wb_row >= NEAR_BASE && mig_wb_row != mig_src_row));
  // R11: response two edges after the request
  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_valid);
endmodule

// File: tb/test_near_row_cache.sv
`timescale 1ns/1ps
module test_near_row_cache;
  localparam int NB = 8, NS = 32, N = 4;

  logic       clk = 1'b0, rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_bank = '0;
  logic [4:0] req_sub = '0;
  logic [8:0] req_row = '0;
  logic       rsp_valid, rsp_hit, mig_valid;
  logic [8:0] rsp_row, mig_src_row, mig_dst_row, mig_wb_row;
  logic [1:0] mig_kind;
  logic [2:0] mig_bank;
  logic [4:0] mig_sub;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: recency stamps instead of ages
  bit m_valid [NB*NS][N];
  bit m_dirty [NB*NS][N];
  int m_tag   [NB*NS][N];
  int m_stamp [NB*NS][N];
  int now = 0;
  int last_hit, last_dst, last_kind, last_wb;

  always #2.5 clk = ~clk;

  near_row_cache i_near_row_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_sub(req_sub), .req_row(req_row),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_row(rsp_row),
    .mig_valid(mig_valid), .mig_kind(mig_kind), .mig_bank(mig_bank), .mig_sub(mig_sub),
    .mig_src_row(mig_src_row), .mig_dst_row(mig_dst_row), .mig_wb_row(mig_wb_row));

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_set(input int idx, input int w, input int r, input bit dirty);
    now++;
    m_valid[idx][w] = 1'b1;
    m_tag[idx][w]   = r;
    m_dirty[idx][w] = dirty;
    m_stamp[idx][w] = now;
  endtask

  // one isolated request, starts and ends just after a falling edge
  task automatic access(input int b, input int s, input int r, input bit wr, input string rq);
    int idx = b*NS + s;
    int hw = -1, fw = -1, lw = 0, way, e_kind, e_wb = 0;
    bit e_hit;
    for (int w = 0; w < N; w++) if (m_valid[idx][w] && m_tag[idx][w] == r) hw = w;
    for (int w = N-1; w >= 0; w--) if (!m_valid[idx][w]) fw = w;
    for (int w = 1; w < N; w++) if (m_stamp[idx][w] < m_stamp[idx][lw]) lw = w;
    e_hit  = (hw >= 0);
    way    = e_hit ? hw : ((fw >= 0) ? fw : lw);
    e_kind = e_hit ? 0 : ((fw < 0 && m_dirty[idx][way]) ? 2 : 1);
    if (e_kind == 2) e_wb = N + m_tag[idx][way];
    req_valid = 1'b1; req_write = wr; req_bank = 3'(b); req_sub = 5'(s); req_row = 9'(r);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "rsp_valid one edge after request", int'(rsp_valid), 0);
    @(negedge clk);
    chk("R11", "rsp_valid two edges after request", int'(rsp_valid), 1);
    chk(rq, "rsp_hit", int'(rsp_hit), int'(e_hit));
    chk(e_hit ? "R3" : "R2", "rsp_row", int'(rsp_row), e_hit ? way : N + r);
    chk("R4", "mig_valid", int'(mig_valid), int'(!e_hit));
    chk("R7", "mig_kind", int'(mig_kind), e_kind);
    if (!e_hit) begin
      chk(rq, "mig_dst_row", int'(mig_dst_row), way);
      chk("R2", "mig_src_row", int'(mig_src_row), N + r);
      chk("R2", "mig_bank/sub", int'({mig_bank, mig_sub}), b*NS + s);
      if (e_kind == 2) chk("R8", "mig_wb_row", int'(mig_wb_row), e_wb);
    end
    last_hit = rsp_hit; last_dst = mig_dst_row; last_kind = mig_kind; last_wb = mig_wb_row;
    model_set(idx, way, r, e_hit ? (m_dirty[idx][way] | wr) : wr);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "mig_valid after reset", int'(mig_valid), 0);
    chk("R1", "mig_kind after reset", int'(mig_kind), 0);
    access(0, 0, 0, 1'b0, "R1");
    chk("R1", "first access misses", last_hit, 0);
    access(7, 31, 503, 1'b0, "R1");
    chk("R1", "top set first access misses", last_hit, 0);
  endtask

  task automatic t_fill_order;
    int rows [4] = '{10, 20, 30, 40};
    foreach (rows[i]) begin
      access(3, 5, rows[i], 1'b0, "R5");
      chk("R5", "lowest empty fast row", last_dst, i);
      chk("R7", "fill into empty row", last_kind, 1);
    end
  endtask

  task automatic t_hits;
    access(3, 5, 20, 1'b0, "R3");
    chk("R3", "hit on row 20", last_hit, 1);
    access(3, 5, 10, 1'b0, "R3");
    chk("R3", "hit on row 10", last_hit, 1);
  endtask

  task automatic t_lru;
    access(3, 5, 50, 1'b0, "R6");
    chk("R6", "evicts least recent (row 30 in fast row 2)", last_dst, 2);
    chk("R7", "clean eviction is plain fill", last_kind, 1);
    access(3, 5, 30, 1'b0, "R6");
    chk("R6", "evicted row misses, replaces fast row 3", last_dst, 3);
  endtask

  task automatic t_dirty;
    access(3, 5, 10, 1'b1, "R8");
    chk("R8", "write hit", last_hit, 1);
    access(3, 5, 60, 1'b0, "R6");
    access(3, 5, 70, 1'b0, "R6");
    access(3, 5, 80, 1'b0, "R6");
    access(3, 5, 90, 1'b0, "R8");
    chk("R8", "modified victim gives write-back", last_kind, 2);
    chk("R8", "write-back row of slow row 10", last_wb, 14);
    chk("R8", "reuses fast row 0", last_dst, 0);
    access(3, 5, 100, 1'b1, "R8");
    access(3, 5, 110, 1'b0, "R6");
    access(3, 5, 120, 1'b0, "R6");
    access(3, 5, 130, 1'b0, "R7");
    chk("R7", "clean victim after write elsewhere", last_kind, 1);
    access(3, 5, 140, 1'b0, "R8");
    chk("R8", "write miss marked modified", last_kind, 2);
    chk("R8", "write-back row of slow row 100", last_wb, 104);
  endtask

  task automatic t_indep;
    access(3, 6, 140, 1'b0, "R9");
    chk("R9", "neighbour subarray misses", last_hit, 0);
    access(4, 5, 140, 1'b0, "R9");
    chk("R9", "neighbour bank misses", last_hit, 0);
    access(3, 5, 140, 1'b0, "R9");
    chk("R9", "original set still hits", last_hit, 1);
  endtask

  task automatic t_back_to_back;
    int idx = 1*NS + 2;
    req_valid = 1'b1; req_write = 1'b0; req_bank = 3'd1; req_sub = 5'd2; req_row = 9'd300;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "first of pair misses", int'(rsp_hit), 0);
    chk("R10", "first of pair fills fast row 0", int'(mig_dst_row), 0);
    chk("R11", "first of pair response valid", int'(rsp_valid), 1);
    @(negedge clk);
    chk("R11", "second of pair response valid", int'(rsp_valid), 1);
    chk("R10", "second of pair hits", int'(rsp_hit), 1);
    chk("R10", "second of pair row", int'(rsp_row), 0);
    chk("R10", "second of pair no command", int'(mig_valid), 0);
    model_set(idx, 0, 300, 1'b0);
    @(negedge clk);
    chk("R11", "no response without request", int'(rsp_valid), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_order();
    t_hits();
    t_lru();
    t_dirty();
    t_indep();
    t_back_to_back();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule